// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes configuration words from a three-wire serial port: a serial clock, a serial data line and a load strobe line. Each word is 17 bits long and arrives most-significant bit first. When the load strobe rises, the word is written into one of two holding registers, and the final bit of the word picks which one. The divider register holds an 11-bit main count and a 5-bit swallow count. The reference register holds a 13-bit reference count. That count follows a fixed divide-by-8 stage downstream, so the reference ratio is eight times the stored value.

All three serial lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block finds the edges in the system clock domain. The serial clock must therefore run well below the system clock: each level must last at least three system clock cycles. A word with the wrong bit count is dropped. A reference count below the legal minimum is raised to the minimum. Each register raises its own one-cycle update strobe when it is written, so downstream counters can reload.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is held and after its release, the swallow count reads 0, the main count reads 0, the reference count reads 5 and both update strobes are low.
- R2: A frame is 17 serial bits sent most-significant bit first. The 17th bit is the register select, and 0 selects the divider register. In that case the first 11 bits sent are the main count (MSB first) and the next 5 bits are the swallow count (MSB first).
- R3: When the select bit is 1, the reference count takes the bits sent in positions 4 through 16, MSB first. The first three bits of that frame are ignored.
- R4: A reference count below 5 is stored as 5. Values from 5 to 8191 are stored as sent.
- R5: A frame that loads a register pulses only that register's update strobe, for exactly one system clock cycle. The other register keeps its value.
- R6: When the load strobe rises after a bit count other than 17 (for example 16 or 18), neither register changes and no update strobe pulses. The bit count restarts at zero after every load strobe rise.
- R7: Serial clock edges that arrive while the load strobe is high shift no bits and add nothing to the bit count.
- R8: A data bit is captured only on a rising serial clock edge. A data change while the serial clock is high has no effect.
- R9: The written register and its update strobe change on the third system clock rising edge after the load strobe input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Asynchronous serial bit clock |
| ser_data | input | 1 | Asynchronous serial data, MSB first |
| ser_load | input | 1 | Asynchronous load strobe; its rising edge commits the frame |
| swallow_cnt | output | 5 | Stored swallow count |
| main_cnt | output | 11 | Stored main count |
| ref_cnt | output | 13 | Stored reference count (5 to 8191) |
| div_upd | output | 1 | One-cycle pulse when the divider register is written |
| ref_upd | output | 1 | One-cycle pulse when the reference register is written |

## Verification
The bench sends divider frames and reference frames with distinct bit patterns. Reading them back shows whether the field boundaries and the bit order are right, and whether the ignored upper bits of a reference frame leak into the count. Frames of 16 and 18 bits, and serial clocks sent while the load strobe is high, separate correct bit counting from counting that drifts. Reference counts of 0, 2, 5 and 8191 cover the clamp edge. A frame in which the data line toggles while the serial clock is high shows that only rising edges capture data. A cycle-counted load shows the three-cycle latency. A behavioural model follows every cycle, so any strobe that is late, missing or extra is caught.

// File: rtl/cfg_loader_pkg.sv
// Package: shared types and helpers for the serial configuration loader.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package cfg_loader_pkg;

    // Meaning of the final frame bit.
    typedef enum logic {
        SEL_DIVIDER   = 1'b0,
        SEL_REFERENCE = 1'b1
    } latch_sel_e;

    // Raise a reference count to the floor value when it falls below it.
    function automatic logic [31:0] floor_clamp(input logic [31:0] raw, input logic [31:0] floor_v);
        return (raw < floor_v) ? floor_v : raw;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
// Module: multi-bit level synchronizer.
// Each bit runs through STAGES flops in series. The bits are independent
// levels, so no bus coherence is assumed. Reset clears every stage.
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    // Remaining stages: settle metastability.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_frame_rx.sv
// Module: serial frame receiver.
// Finds serial clock and load strobe edges from synchronized levels. On a
// serial clock rise it shifts in one bit, unless the load strobe is high.
// On a load strobe rise it flags a complete frame if exactly FRAME_BITS bits
// were counted. Assumes each serial level lasts at least three system clocks.
module cfg_frame_rx #(
    parameter int FRAME_BITS = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_s,
    input  logic                  sdat_s,
    input  logic                  load_s,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  frame_ok
);

    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic                  sclk_q, load_q;
    logic                  sclk_rise, load_rise;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;

    assign sclk_rise = sclk_s & ~sclk_q & ~load_s;
    assign load_rise = load_s & ~load_q;

    // Hold last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            load_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            load_q <= load_s;
        end
    end

    // Shift in bits and count them; restart the count on every load rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (load_rise) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], sdat_s};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_word = shreg;
    assign frame_ok   = load_rise && (bit_cnt == CNT_FULL);

    // R7: a high load strobe freezes the shift register.
    assert_load_blocks_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> $stable(shreg));

    // R6: the bit counter never runs past its saturation value.
    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_SAT);

endmodule

// File: rtl/cfg_latch_bank.sv
// Module: the two holding registers.
// On a valid frame, bit 0 selects the target. The divider register takes
// main and swallow counts from the data bits. The reference register takes
// the low B_W data bits, raised to B_MIN when smaller. The target's update
// strobe is registered together with the value.
module cfg_latch_bank
    import cfg_loader_pkg::*;
#(
    parameter int S_W   = 5,
    parameter int M_W   = 11,
    parameter int B_W   = 13,
    parameter int B_MIN = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_ok,
    input  logic [M_W+S_W:0]   frame_word,
    output logic [S_W-1:0]     swallow_cnt,
    output logic [M_W-1:0]     main_cnt,
    output logic [B_W-1:0]     ref_cnt,
    output logic               div_upd,
    output logic               ref_upd
);

    localparam int DATA_W = M_W + S_W;
    localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);

    latch_sel_e          sel;
    logic [DATA_W-1:0]   data_bits;
    logic [B_W-1:0]      b_clamped;

    assign sel       = latch_sel_e'(frame_word[0]);
    assign data_bits = frame_word[DATA_W:1];
    assign b_clamped = B_W'(floor_clamp(32'(data_bits[B_W-1:0]), 32'(B_MIN)));

    // Divider register: main and swallow counts with their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_cnt    <= '0;
            swallow_cnt <= '0;
            div_upd     <= 1'b0;
        end else begin
            div_upd <= frame_ok && (sel == SEL_DIVIDER);
            if (frame_ok && (sel == SEL_DIVIDER)) begin
                main_cnt    <= data_bits[DATA_W-1 -: M_W];
                swallow_cnt <= data_bits[S_W-1:0];
            end
        end
    end

    // Reference register: clamped count with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= B_FLOOR;
            ref_upd <= 1'b0;
        end else begin
            ref_upd <= frame_ok && (sel == SEL_REFERENCE);
            if (frame_ok && (sel == SEL_REFERENCE)) ref_cnt <= b_clamped;
        end
    end

    // R5: the two strobes never fire together.
    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_upd && ref_upd));

    // R4: the stored reference count never drops below the floor.
    assert_ref_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt >= B_FLOOR);

    // R5: divider values change only alongside their strobe.
    assert_div_change_strobed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({main_cnt, swallow_cnt}) |-> div_upd);

    // R5: reference value changes only alongside its strobe.
    assert_ref_change_strobed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_cnt) |-> ref_upd);

endmodule

// File: rtl/cfg_serial_loader.sv
// Module: top of the three-wire serial configuration loader.
// Synchronizes the serial lines to clk, assembles 17-bit frames and writes
// them into the divider or reference register. Assumes the serial lines
// change slowly compared with clk (three clk cycles per level or more).
module cfg_serial_loader #(
    parameter int S_W         = 5,
    parameter int M_W         = 11,
    parameter int B_W         = 13,
    parameter int B_MIN       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [S_W-1:0] swallow_cnt,
    output logic [M_W-1:0] main_cnt,
    output logic [B_W-1:0] ref_cnt,
    output logic           div_upd,
    output logic           ref_upd
);

    localparam int FRAME_BITS = M_W + S_W + 1;

    logic [2:0]            lines_s;
    logic [FRAME_BITS-1:0] frame_word;
    logic                  frame_ok;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk, ser_data, ser_load}),
        .sync_out (lines_s)
    );

    cfg_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (lines_s[2]),
        .sdat_s     (lines_s[1]),
        .load_s     (lines_s[0]),
        .frame_word (frame_word),
        .frame_ok   (frame_ok)
    );

    cfg_latch_bank #(.S_W(S_W), .M_W(M_W), .B_W(B_W), .B_MIN(B_MIN)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ok    (frame_ok),
        .frame_word  (frame_word),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .ref_cnt     (ref_cnt),
        .div_upd     (div_upd),
        .ref_upd     (ref_upd)
    );

endmodule

// File: tb/cfg_serial_loader_bench.sv
// Bench: directed frames plus a behavioural per-cycle model compared each clock.
module cfg_serial_loader_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [4:0]  swallow_cnt;
    logic [10:0] main_cnt;
    logic [12:0] ref_cnt;
    logic        div_upd, ref_upd;

    int total = 0;
    int bad   = 0;
    int n_div = 0, n_ref = 0;
    bit model_on = 0;

    always #5 clk = ~clk;

    cfg_serial_loader u_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
        .ref_cnt(ref_cnt), .div_upd(div_upd), .ref_upd(ref_upd)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---- behavioural model: input history, integer state ----
    logic [2:0] h1 = 0, h2 = 0, h3 = 0;   // {clk,data,load} sampled 1,2,3 edges ago
    int m_sr = 0, m_cnt = 0, m_s = 0, m_m = 0, m_b = 5, m_ud = 0, m_ur = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_sr = 0; m_cnt = 0; m_s = 0; m_m = 0; m_b = 5; m_ud = 0; m_ur = 0;
        end else begin
            m_ud = 0; m_ur = 0;
            if (h2[0] && !h3[0]) begin
                if (m_cnt == 17) begin
                    if ((m_sr & 1) == 0) begin
                        m_m = (m_sr >> 6) & 2047; m_s = (m_sr >> 1) & 31; m_ud = 1;
                    end else begin
                        m_b = (m_sr >> 1) & 8191; if (m_b < 5) m_b = 5; m_ur = 1;
                    end
                end
                m_cnt = 0;
            end else if (h2[2] && !h3[2] && !h2[0]) begin
                m_sr = ((m_sr << 1) | int'(h2[1])) & 32'h1FFFF;
                if (m_cnt < 18) m_cnt++;
            end
            h3 = h2; h2 = h1; h1 = {ser_clk, ser_data, ser_load};
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R2 model swallow", int'(swallow_cnt), m_s);
            check("R2 model main", int'(main_cnt), m_m);
            check("R3 model ref", int'(ref_cnt), m_b);
            check("R5 model div_upd", int'(div_upd), m_ud);
            check("R5 model ref_upd", int'(ref_upd), m_ur);
        end
        if (div_upd) n_div++;
        if (ref_upd) n_ref++;
    end

    // ---- stimulus helpers ----
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        ser_data = b; tick(3);
        ser_clk = 1'b1; tick(3);
        if (glitch) begin ser_data = ~b; tick(3); end
        ser_clk = 1'b0; tick(3);
    endtask

    task automatic send_bits(input logic [31:0] w, input int n, input bit glitch);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i], glitch);
        ser_data = 1'b0;
    endtask

    task automatic pulse_load();
        ser_load = 1'b1; tick(5);
        ser_load = 1'b0; tick(5);
    endtask

    task automatic div_frame(input int m, input int s);
        n_div = 0; n_ref = 0;
        send_bits({15'd0, 11'(m), 5'(s), 1'b0}, 17, 0);
        pulse_load();
    endtask

    task automatic ref_frame(input int b, input int top3);
        n_div = 0; n_ref = 0;
        send_bits({15'd0, 3'(top3), 13'(b), 1'b1}, 17, 0);
        pulse_load();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        // R1: reset values while held
        check("R1 swallow", int'(swallow_cnt), 0);
        check("R1 main", int'(main_cnt), 0);
        check("R1 ref", int'(ref_cnt), 5);
        check("R1 strobes", int'({div_upd, ref_upd}), 0);
        rst_n = 1'b1;
        model_on = 1;
        tick(3);
        check("R1 after release", int'(ref_cnt), 5);

        // R2: divider frame, bit order and field split
        div_frame(1234, 17);
        check("R2 main", int'(main_cnt), 1234);
        check("R2 swallow", int'(swallow_cnt), 17);
        check("R5 div strobe count", n_div, 1);
        check("R5 no ref strobe", n_ref, 0);
        check("R5 ref kept", int'(ref_cnt), 5);

        div_frame(32, 31);
        check("R2 main 32", int'(main_cnt), 32);
        check("R2 swallow 31", int'(swallow_cnt), 31);

        // R3: reference frame, upper three bits ignored
        ref_frame(6000, 5);
        check("R3 ref", int'(ref_cnt), 6000);
        check("R5 ref strobe count", n_ref, 1);
        check("R5 no div strobe", n_div, 0);
        check("R5 main kept", int'(main_cnt), 32);
        ref_frame(8191, 7);
        check("R4 ref max", int'(ref_cnt), 8191);

        // R4: clamp below floor
        ref_frame(2, 0);
        check("R4 ref 2 clamped", int'(ref_cnt), 5);
        ref_frame(100, 0);
        ref_frame(0, 0);
        check("R4 ref 0 clamped", int'(ref_cnt), 5);
        ref_frame(5, 2);
        check("R4 ref 5 kept", int'(ref_cnt), 5);

        // R6: wrong bit counts discarded
        n_div = 0; n_ref = 0;
        send_bits(32'h0000_FFFE, 16, 0); pulse_load();
        check("R6 16 bits main", int'(main_cnt), 32);
        check("R6 16 bits strobes", n_div + n_ref, 0);
        n_div = 0; n_ref = 0;
        send_bits(32'h0003_FFFE, 18, 0); pulse_load();
        check("R6 18 bits swallow", int'(swallow_cnt), 31);
        check("R6 18 bits strobes", n_div + n_ref, 0);

        // R7: clocks with load high do not count
        ser_load = 1'b1; tick(4);
        send_bits(32'h0000_001F, 5, 0);
        ser_load = 1'b0; tick(4);
        div_frame(777, 9);
        check("R7 frame after blocked clocks", int'(main_cnt), 777);
        ser_load = 1'b1; tick(4);
        n_div = 0; n_ref = 0;
        send_bits({15'd0, 11'd55, 5'd3, 1'b0}, 17, 0);
        ser_load = 1'b0; tick(4);
        pulse_load();
        check("R7 blocked frame not loaded", int'(main_cnt), 777);
        check("R7 blocked frame strobes", n_div + n_ref, 0);

        // R8: data toggled while serial clock high
        n_div = 0; n_ref = 0;
        send_bits({15'd0, 11'd1365, 5'd10, 1'b0}, 17, 1);
        pulse_load();
        check("R8 main with glitch", int'(main_cnt), 1365);
        check("R8 swallow with glitch", int'(swallow_cnt), 10);

        // R9: latency from load rise to strobe
        send_bits({15'd0, 3'd0, 13'd4321, 1'b1}, 17, 0);
        ser_load = 1'b1;
        tick(1); check("R9 edge1 strobe", int'(ref_upd), 0);
        tick(1); check("R9 edge2 strobe", int'(ref_upd), 0);
        tick(1); check("R9 edge3 strobe", int'(ref_upd), 1);
        check("R9 edge3 value", int'(ref_cnt), 4321);
        tick(1); check("R9 edge4 strobe", int'(ref_upd), 0);
        ser_load = 1'b0; tick(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule